// File: doc/BRIEF.md
# Programmable Embedded-Sync Video Decoder

This block receives an 8-bit BT.656 byte stream together with its pixel clock. There are no separate horizontal or vertical sync wires. Timing is carried only by the embedded four-byte sync words: three preamble bytes, then a status byte. The block watches for the preamble, which software programs. It takes the H, V and F flags out of the status byte and classifies the word against two programmable per-field code registers. Each register holds 3-bit {H,V,F} codes for four phases: active start, active end, blanking start and blanking end. The blanking codes come as a first-blanking and a second-blanking pair.

Downstream capture logic uses the outputs directly. It receives the active pixel bytes with a valid strobe, the current field identity, blanking and active status, and one-cycle start-of-frame and end-of-frame pulses. The frame pulses follow a strict code sequence. A stream whose codes never match the programmed values therefore never reports a completed frame. A status word that matches no programmed code raises a sticky error flag. Software clears the flag by pulsing a clear input.

Top module: `embsync_decoder`

## Requirements
- R1: After reset, pix_valid, sof, eof, sync_err, in_active and field_id are 0 and in_blank is 1.
- R2: A status byte is recognised only when the three bytes before it equal sync_pre[23:16], sync_pre[15:8] and sync_pre[7:0], oldest first. With any other preamble the outputs keep their reset values.
- R3: The code taken from a status byte is {H,V,F} = {bit 4, bit 5, bit 6}. Bits 7 and 3:0 of the status byte have no effect.
- R4: Each code register is laid out as follows: active start in [21:19], active end in [18:16], second-blanking start in [11:9], second-blanking end in [8:6], first-blanking start in [5:3] and first-blanking end in [2:0]. Bits [15:12] are unused. code_f0 is checked before code_f1. Within a register the check order is active start, active end, either blanking start, then either blanking end.
- R5: pix_valid marks exactly the bytes that follow a status word classified as active start, up to the byte before the next preamble. pix_byte carries those bytes in stream order.
- R6: After a matched word, field_id is 0 for a code_f0 match and 1 for a code_f1 match. A blanking code gives in_blank=1 and in_active=0. An active code gives in_blank=0 and in_active=1.
- R7: sof pulses for one cycle on a code_f0 active-start match when no frame is in progress.
- R8: eof pulses once, on the first code_f0 match that follows a code_f1 active-start match inside a frame. If code_f1 never matches, eof never fires.
- R9: A status word that matches no code sets sync_err, which stays set until err_clr is pulsed. The word leaves field_id, in_blank and in_active unchanged.
- R10: With edge_inv=1 the input byte is latched on the falling clock edge. For the same stream the outputs are identical to those with edge_inv=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_inv | input | 1 | 1: latch input on falling edge |
| pix_data | input | DATA_W (8) | Incoming video byte |
| code_f0 | input | 22 | Field 0 code register |
| code_f1 | input | 22 | Field 1 code register |
| sync_pre | input | PRE_BYTES*DATA_W (24) | Preamble bytes, oldest in the top byte |
| err_clr | input | 1 | Write-one pulse clearing sync_err |
| pix_valid | output | 1 | pix_byte holds an active byte |
| pix_byte | output | DATA_W (8) | Active byte, delayed |
| field_id | output | 1 | Field of the last matched word |
| in_blank | output | 1 | Last matched word was a blanking code |
| in_active | output | 1 | Last matched word was an active code |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-frame pulse |
| sync_err | output | 1 | Sticky unmatched-code flag |

## Verification
The assertions assume the stream follows BT.656 rules. In particular, no payload byte equals 0xFF, so a valid output byte can never be a preamble byte. They also assume that two status words are always separated by at least the preamble length. The stimulus keeps within these limits in every scenario. Payload bytes are drawn from 0x20..0xDF, blanking filler alternates between 0x80 and 0x10, and every status word is preceded by a full three-byte preamble with at least eight bytes of horizontal blanking between words.

// File: rtl/embsync_pkg.sv
package embsync_pkg;
    localparam int CODE_W      = 3;
    localparam int FIELD_REG_W = 22;

    // code field offsets inside a per-field register (layout is decoded by software)
    localparam int OFS_ACT_START = 19;
    localparam int OFS_ACT_END   = 16;
    localparam int OFS_B2_START  = 9;
    localparam int OFS_B2_END    = 6;
    localparam int OFS_B1_START  = 3;
    localparam int OFS_B1_END    = 0;
    localparam int RESV_HI       = 15;
    localparam int RESV_LO       = 12;

    // flag positions inside the status byte
    localparam int BIT_F = 6;
    localparam int BIT_V = 5;
    localparam int BIT_H = 4;

    localparam int NUM_FIELDS = 2;

    typedef enum logic [1:0] {
        K_ACT_START,
        K_ACT_END,
        K_BLK_START,
        K_BLK_END
    } code_kind_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_FIRST,
        FR_SECOND
    } frame_phase_e;

    typedef struct packed {
        logic         run;
        logic         field;
        logic         blank;
        logic         active;
        logic         err;
        frame_phase_e phase;
        logic         sof;
        logic         eof;
    } dec_state_t;
endpackage

// File: rtl/embsync_capture.sv
module embsync_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_inv_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] neg_q;
    logic [DATA_W-1:0] pos_d, pos_q;

    // falling-edge sample, used when the inverted latch edge is selected
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= data_i;
    end

    always_comb begin
        pos_d = edge_inv_i ? neg_q : data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign data_o = pos_q;
endmodule

// File: rtl/embsync_code_match.sv
module embsync_code_match
    import embsync_pkg::*;
(
    input  logic [CODE_W-1:0]      code_i,
    input  logic [FIELD_REG_W-1:0] cfg_i,
    output logic                   hit_o,
    output code_kind_e             kind_o
);
    logic [CODE_W-1:0] c_as, c_ae, c_b2s, c_b2e, c_b1s, c_b1e;
    logic              unused_resv;

    assign c_as  = cfg_i[OFS_ACT_START +: CODE_W];
    assign c_ae  = cfg_i[OFS_ACT_END   +: CODE_W];
    assign c_b2s = cfg_i[OFS_B2_START  +: CODE_W];
    assign c_b2e = cfg_i[OFS_B2_END    +: CODE_W];
    assign c_b1s = cfg_i[OFS_B1_START  +: CODE_W];
    assign c_b1e = cfg_i[OFS_B1_END    +: CODE_W];
    assign unused_resv = ^cfg_i[RESV_HI:RESV_LO];

    always_comb begin
        hit_o  = 1'b1;
        kind_o = K_ACT_START;
        if (code_i == c_as) begin
            kind_o = K_ACT_START;
        end else if (code_i == c_ae) begin
            kind_o = K_ACT_END;
        end else if ((code_i == c_b2s) || (code_i == c_b1s)) begin
            kind_o = K_BLK_START;
        end else if ((code_i == c_b2e) || (code_i == c_b1e)) begin
            kind_o = K_BLK_END;
        end else begin
            hit_o = 1'b0;
        end
    end
endmodule

// File: rtl/embsync_align.sv
module embsync_align #(
    parameter int DATA_W    = 8,
    parameter int PRE_BYTES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             data_i,
    input  logic                          tag_i,
    input  logic                          drop_i,
    output logic [PRE_BYTES*DATA_W-1:0]   window_o,
    output logic [DATA_W-1:0]             data_o,
    output logic                          tag_o
);
    localparam int DEPTH = PRE_BYTES + 1;

    logic [DEPTH-1:0][DATA_W-1:0] byte_d, byte_q;
    logic [DEPTH-1:0]             tag_d, tag_q;

    // stage 0 is the newest byte; a detected sync word untags the preamble in flight
    always_comb begin
        byte_d[0] = data_i;
        tag_d[0]  = tag_i;
        for (int k = 1; k < DEPTH; k++) begin
            byte_d[k] = byte_q[k-1];
            tag_d[k]  = tag_q[k-1] & ~drop_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            tag_q  <= '0;
        end else begin
            byte_q <= byte_d;
            tag_q  <= tag_d;
        end
    end

    for (genvar w = 0; w < PRE_BYTES; w++) begin : g_window
        assign window_o[w*DATA_W +: DATA_W] = byte_q[w];
    end

    assign data_o = byte_q[DEPTH-1];
    assign tag_o  = tag_q[DEPTH-1];
endmodule

// File: rtl/embsync_decoder.sv
module embsync_decoder
    import embsync_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PRE_BYTES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        edge_inv,
    input  logic [DATA_W-1:0]           pix_data,
    input  logic [FIELD_REG_W-1:0]      code_f0,
    input  logic [FIELD_REG_W-1:0]      code_f1,
    input  logic [PRE_BYTES*DATA_W-1:0] sync_pre,
    input  logic                        err_clr,
    output logic                        pix_valid,
    output logic [DATA_W-1:0]           pix_byte,
    output logic                        field_id,
    output logic                        in_blank,
    output logic                        in_active,
    output logic                        sof,
    output logic                        eof,
    output logic                        sync_err
);
    localparam int PRE_W = PRE_BYTES * DATA_W;

    logic [DATA_W-1:0]                  cur_byte;
    logic [PRE_W-1:0]                   window;
    logic                               status_now;
    logic [CODE_W-1:0]                  code;
    logic [NUM_FIELDS-1:0][FIELD_REG_W-1:0] cfg_arr;
    logic [NUM_FIELDS-1:0]              hit;
    code_kind_e                         kind_arr [NUM_FIELDS];
    logic                               any_hit;
    logic                               hit_field;
    code_kind_e                         hit_kind;
    frame_phase_e                       ph_mid;
    dec_state_t                         st_d, st_q;

    embsync_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_inv_i (edge_inv),
        .data_i     (pix_data),
        .data_o     (cur_byte)
    );

    embsync_align #(.DATA_W(DATA_W), .PRE_BYTES(PRE_BYTES)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (cur_byte),
        .tag_i    (st_q.run & ~status_now),
        .drop_i   (status_now),
        .window_o (window),
        .data_o   (pix_byte),
        .tag_o    (pix_valid)
    );

    assign status_now = (window == sync_pre);
    assign code       = {cur_byte[BIT_H], cur_byte[BIT_V], cur_byte[BIT_F]};
    assign cfg_arr    = {code_f1, code_f0};

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        embsync_code_match u_match (
            .code_i (code),
            .cfg_i  (cfg_arr[g]),
            .hit_o  (hit[g]),
            .kind_o (kind_arr[g])
        );
    end

    // field 0 register has priority when both match
    always_comb begin
        any_hit   = |hit;
        hit_field = 1'b0;
        hit_kind  = kind_arr[0];
        if (!hit[0] && hit[1]) begin
            hit_field = 1'b1;
            hit_kind  = kind_arr[1];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.sof = 1'b0;
        st_d.eof = 1'b0;
        st_d.err = st_q.err & ~err_clr;
        ph_mid   = st_q.phase;
        if (status_now) begin
            if (!any_hit) begin
                st_d.err = 1'b1;
            end else begin
                st_d.field = hit_field;
                case (hit_kind)
                    K_ACT_START: begin
                        st_d.run    = 1'b1;
                        st_d.blank  = 1'b0;
                        st_d.active = 1'b1;
                    end
                    K_ACT_END: begin
                        st_d.run    = 1'b0;
                        st_d.blank  = 1'b0;
                        st_d.active = 1'b1;
                    end
                    default: begin
                        st_d.run    = 1'b0;
                        st_d.blank  = 1'b1;
                        st_d.active = 1'b0;
                    end
                endcase
                // second field finished: first field-0 word after field-1 active
                if (st_q.phase == FR_SECOND && !hit_field) begin
                    st_d.eof = 1'b1;
                    ph_mid   = FR_IDLE;
                end
                if (hit_kind == K_ACT_START) begin
                    if (ph_mid == FR_IDLE && !hit_field) begin
                        st_d.sof = 1'b1;
                        ph_mid   = FR_FIRST;
                    end else if (ph_mid == FR_FIRST && hit_field) begin
                        ph_mid   = FR_SECOND;
                    end
                end
                st_d.phase = ph_mid;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.blank <= 1'b1;
            st_q.phase <= FR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign field_id  = st_q.field;
    assign in_blank  = st_q.blank;
    assign in_active = st_q.active;
    assign sof       = st_q.sof;
    assign eof       = st_q.eof;
    assign sync_err  = st_q.err;
endmodule

// File: rtl/embsync_decoder_chk.sv
module embsync_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_clr,
    input logic              pix_valid,
    input logic [DATA_W-1:0] pix_byte,
    input logic              in_blank,
    input logic              in_active,
    input logic              sof,
    input logic              eof,
    input logic              sync_err
);
    assert_sof_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    assert_eof_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_blank && in_active));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !err_clr) |=> sync_err);

    assert_no_preamble_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_byte != {DATA_W{1'b1}}));
endmodule

bind embsync_decoder embsync_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_clr   (err_clr),
    .pix_valid (pix_valid),
    .pix_byte  (pix_byte),
    .in_blank  (in_blank),
    .in_active (in_active),
    .sof       (sof),
    .eof       (eof),
    .sync_err  (sync_err)
);

// File: tb/embsync_decoder_bench.sv
module embsync_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;
    localparam int ACT_BYTES  = 1440;
    localparam int HB_BYTES   = 8;
    localparam int BL_BYTES   = 16;
    localparam int N_BLANK    = 2;
    localparam int N_ACT      = 3;
    localparam logic [21:0] REG_F0 = 22'h40596;
    localparam logic [21:0] REG_F1 = 22'hD07DF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_inv = 1'b0;
    logic [7:0]  pix_data = 8'h10;
    logic [21:0] code_f0 = REG_F0;
    logic [21:0] code_f1 = REG_F1;
    logic [23:0] sync_pre = 24'hFF0000;
    logic        err_clr = 1'b0;
    logic        pix_valid, field_id, in_blank, in_active, sof, eof, sync_err;
    logic [7:0]  pix_byte;

    int checks = 0;
    int fails = 0;
    int n_sof, n_eof, n_pix, pix_sum, exp_pix, exp_sum, line_no;

    embsync_decoder u_embsync_decoder (
        .clk(clk), .rst_n(rst_n), .edge_inv(edge_inv), .pix_data(pix_data),
        .code_f0(code_f0), .code_f1(code_f1), .sync_pre(sync_pre), .err_clr(err_clr),
        .pix_valid(pix_valid), .pix_byte(pix_byte), .field_id(field_id),
        .in_blank(in_blank), .in_active(in_active), .sof(sof), .eof(eof),
        .sync_err(sync_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sof) n_sof++;
            if (eof) n_eof++;
            if (pix_valid) begin
                n_pix++;
                pix_sum += int'(pix_byte);
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk);
        #1 pix_data = b;
    endtask

    task automatic send_sync(input bit h, input bit v, input bit f, input logic [3:0] prot);
        send(8'hFF);
        send(8'h00);
        send(8'h00);
        send({1'b1, f, v, h, prot});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send((i % 2) ? 8'h10 : 8'h80);
    endtask

    task automatic send_line(input bit f, input bit blank);
        send_sync(1'b1, blank, f, line_no[3:0]);
        idle(HB_BYTES);
        send_sync(1'b0, blank, f, ~line_no[3:0]);
        if (blank) begin
            idle(BL_BYTES);
        end else begin
            for (int k = 0; k < ACT_BYTES; k++) begin
                logic [7:0] b;
                b = 8'(32 + ((k + line_no) % 192));
                send(b);
                exp_sum += int'(b);
                exp_pix++;
            end
        end
        line_no++;
    endtask

    task automatic send_field(input bit f);
        for (int i = 0; i < N_BLANK; i++) send_line(f, 1'b1);
        for (int i = 0; i < N_ACT; i++) send_line(f, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        err_clr = 1'b0;
        pix_data = 8'h10;
        repeat (3) @(posedge clk);
        n_sof = 0; n_eof = 0; n_pix = 0; pix_sum = 0;
        exp_pix = 0; exp_sum = 0; line_no = 0;
        #1 rst_n = 1'b1;
    endtask

    task automatic test_reset();
        code_f0 = REG_F0; code_f1 = REG_F1; sync_pre = 24'hFF0000; edge_inv = 1'b0;
        do_reset();
        @(negedge clk);
        chk(pix_valid == 1'b0, "R1 pix_valid", int'(pix_valid), 0);
        chk(sof == 1'b0 && eof == 1'b0, "R1 sof/eof", int'({sof, eof}), 0);
        chk(sync_err == 1'b0, "R1 sync_err", int'(sync_err), 0);
        chk(in_blank == 1'b1 && in_active == 1'b0, "R1 blank/active", int'({in_blank, in_active}), 2);
        chk(field_id == 1'b0, "R1 field_id", int'(field_id), 0);
    endtask

    // two frames; first stream field uses F value fa, second uses ~fa
    task automatic run_two_frames(input bit fa, input string tag);
        for (int fr = 0; fr < 2; fr++) begin
            send_field(fa);
            @(negedge clk);
            chk(field_id == 1'b0 && in_active == 1'b1, {tag, " R6 first field state"},
                int'({field_id, in_active}), 1);
            send_field(~fa);
            @(negedge clk);
            chk(field_id == 1'b1 && in_active == 1'b1, {tag, " R6 second field state"},
                int'({field_id, in_active}), 3);
        end
        send_line(fa, 1'b1);
        idle(12);
        @(negedge clk);
        chk(n_sof == 2, {tag, " R7 sof count"}, n_sof, 2);
        chk(n_eof == 2, {tag, " R8 eof per field pair"}, n_eof, 2);
        chk(n_pix == exp_pix, {tag, " R5 valid byte count"}, n_pix, exp_pix);
        chk(pix_sum == exp_sum, {tag, " R5 byte content"}, pix_sum, exp_sum);
        chk(sync_err == 1'b0, {tag, " R3 R4 all codes matched"}, int'(sync_err), 0);
        chk(in_blank == 1'b1 && field_id == 1'b0, {tag, " R6 trailing blank"},
            int'({in_blank, field_id}), 2);
    endtask

    task automatic test_pal();
        code_f0 = REG_F0; code_f1 = REG_F1; sync_pre = 24'hFF0000; edge_inv = 1'b0;
        do_reset();
        run_two_frames(1'b0, "pal");
    endtask

    task automatic test_swapped();
        code_f0 = REG_F1; code_f1 = REG_F0; sync_pre = 24'hFF0000; edge_inv = 1'b0;
        do_reset();
        run_two_frames(1'b1, "swap R4");
    endtask

    task automatic test_edge_inv();
        code_f0 = REG_F0; code_f1 = REG_F1; sync_pre = 24'hFF0000; edge_inv = 1'b1;
        do_reset();
        run_two_frames(1'b0, "edge R10");
        edge_inv = 1'b0;
    endtask

    task automatic test_mismatch();
        code_f0 = REG_F0; code_f1 = REG_F0; sync_pre = 24'hFF0000; edge_inv = 1'b0;
        do_reset();
        send_field(1'b0);
        send_field(1'b1);
        @(negedge clk);
        chk(sync_err == 1'b1, "R9 unmatched sets error", int'(sync_err), 1);
        chk(field_id == 1'b0 && in_active == 1'b1, "R9 state unchanged",
            int'({field_id, in_active}), 1);
        send_line(1'b0, 1'b1);
        idle(12);
        @(negedge clk);
        chk(n_eof == 0, "R8 no eof on mismatch", n_eof, 0);
        chk(n_sof == 1, "R7 single sof", n_sof, 1);
        chk(sync_err == 1'b1, "R9 error sticky", int'(sync_err), 1);
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        @(negedge clk);
        chk(sync_err == 1'b0, "R9 cleared by err_clr", int'(sync_err), 0);
    endtask

    task automatic test_preamble();
        code_f0 = REG_F0; code_f1 = REG_F1; sync_pre = 24'hFF0011; edge_inv = 1'b0;
        do_reset();
        send_field(1'b0);
        send_field(1'b1);
        idle(12);
        @(negedge clk);
        chk(n_sof == 0 && n_eof == 0, "R2 no frame events", n_sof + n_eof, 0);
        chk(n_pix == 0, "R2 no valid bytes", n_pix, 0);
        chk(sync_err == 1'b0 && in_blank == 1'b1, "R2 no status seen",
            int'({sync_err, in_blank}), 1);
        sync_pre = 24'hFF0000;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_pal();
        test_swapped();
        test_edge_inv();
        test_mismatch();
        test_preamble();
        summary();
        $finish;
    end
endmodule